// File: doc/BRIEF.md
# PWM Timer Channel with Direct-Write Compare

This block is a free-running up-counter with a programmable wrap limit and one output-compare channel that drives a pulse-width-modulated pin. Each period begins when the counter wraps to zero, and the pulse ends when the counter reaches the channel's compare value. The compare register has no shadow copy. A write reaches the comparator on the very next cycle, including in the middle of a period.

Software programs the block through a small write port. One address holds the wrap limit, one holds the compare value, one holds the control bits, and one takes a clear strobe for the event flags. At every wrap the output is forced to a known level and is never toggled. A lost or extra event therefore corrects itself at the next wrap, and a 0% duty cycle can be produced. Two sticky flags record compare and wrap events. Each flag has its own enable toward a single interrupt line.

Top module: `pwm_timer_chan`

## Requirements
- R1: While reset is low and on the first cycle after it, count_o, pwm_o, cmp_flag_o, ovf_flag_o and irq_o are all 0.
- R2: Reset loads the wrap limit with all ones, so with no writes the counter runs from 0 to 65535 and then wraps to 0.
- R3: Each clock the counter adds one. On the clock after it equals the wrap limit it returns to 0, and that wrap sets the overflow flag.
- R4: With a compare value C where 1 <= C <= wrap limit, the output holds its active level during counts 0 to C-1 of the period and its inactive level from count C to the wrap limit. The active level is restored at every wrap.
- R5: A compare value of 0 keeps the output at its inactive level for the whole period. A compare value above the wrap limit keeps it active for the whole period.
- R6: Control bit 0 (address 2) sets polarity. At 0 the active level is 1, and at 1 the active level is 0.
- R7: The compare flag is set on the clock at which the counter advances to the compare value. It is never set in a period where the compare value is 0 or above the wrap limit.
- R8: A write to the compare register (address 1) acts on the next cycle within the running period. Raising it before the counter reaches the old value lengthens the current pulse.
- R9: If a compare value below the current count is written before the old value is reached, there is no match for the rest of that period. The output stays active until the wrap and the compare flag stays clear.
- R10: Both flags stay set until cleared. A write to address 3 clears the compare flag with data bit 0 and the overflow flag with data bit 1. A clear and a set on the same clock leave the flag set.
- R11: irq_o is 1 exactly when some flag is set and its enable is on. The compare enable is control bit 1 and the overflow enable is control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 wrap limit, 1 compare, 2 control, 3 flag clear |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| pwm_o | output | 1 | PWM output pin |
| cmp_flag_o | output | 1 | Sticky compare event flag |
| ovf_flag_o | output | 1 | Sticky wrap event flag |
| irq_o | output | 1 | OR of the enabled flags |

## Verification
The assertions assume that wr_addr and wr_data are known whenever wr_en is high. They also assume that any change of the wrap limit is judged against the limit already in the register, so a limit written below the running count only delays the wrap. The stimulus writes a new wrap limit only when the count is zero, and it never shrinks the limit below the count reached. Compare writes are placed away from the clock at which the counter would reach the old value, except in the deliberate skipped-match case.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    typedef enum logic [1:0] {
        ADDR_LIMIT = 2'd0,
        ADDR_CMP   = 2'd1,
        ADDR_CTL   = 2'd2,
        ADDR_CLR   = 2'd3
    } reg_addr_e;

    localparam int CTL_POL_BIT = 0;
    localparam int CTL_CIE_BIT = 1;
    localparam int CTL_OIE_BIT = 2;

    localparam int CLR_CMP_BIT = 0;
    localparam int CLR_OVF_BIT = 1;

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] limit_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             pol_o,
    output logic             cie_o,
    output logic             oie_o,
    output logic             clr_cmp_o,
    output logic             clr_ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] cmpv;
        logic             pol;
        logic             cie;
        logic             oie;
    } regs_t;

    regs_t st_d, st_q;
    reg_addr_e addr;

    always_comb begin
        st_d      = st_q;
        addr      = reg_addr_e'(wr_addr);
        clr_cmp_o = 1'b0;
        clr_ovf_o = 1'b0;
        if (wr_en) begin
            case (addr)
                ADDR_LIMIT: st_d.limit = wr_data;
                ADDR_CMP:   st_d.cmpv  = wr_data;
                ADDR_CTL: begin
                    st_d.pol = wr_data[CTL_POL_BIT];
                    st_d.cie = wr_data[CTL_CIE_BIT];
                    st_d.oie = wr_data[CTL_OIE_BIT];
                end
                ADDR_CLR: begin
                    clr_cmp_o = wr_data[CLR_CMP_BIT];
                    clr_ovf_o = wr_data[CLR_OVF_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.limit <= '1;
            st_q.cmpv  <= '0;
            st_q.pol   <= 1'b0;
            st_q.cie   <= 1'b0;
            st_q.oie   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign limit_o = st_q.limit;
    assign cmp_o   = st_q.cmpv;
    assign pol_o   = st_q.pol;
    assign cie_o   = st_q.cie;
    assign oie_o   = st_q.oie;

endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o,
    output logic             match_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + ONE;
        wrap_o  = (st_q.cnt == limit_i);
        // match means the counter is about to land on the compare value
        match_o = !wrap_o && (cnt_inc == cmp_i);
        if (wrap_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/pwm_tmr_output.sv
module pwm_tmr_output #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap_i,
    input  logic             match_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             pol_i,
    input  logic             cie_i,
    input  logic             oie_i,
    input  logic             clr_cmp_i,
    input  logic             clr_ovf_i,
    output logic             lvl_o,
    output logic             pwm_o,
    output logic             cmp_flag_o,
    output logic             ovf_flag_o,
    output logic             irq_o
);

    typedef struct packed {
        logic lvl;
        logic cmp_flag;
        logic ovf_flag;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // wrap wins over match; a zero compare keeps the pin inactive
        if (wrap_i) begin
            st_d.lvl = (cmp_i != '0);
        end else if (match_i) begin
            st_d.lvl = 1'b0;
        end
        // set has priority over a clear strobe on the same clock
        st_d.cmp_flag = match_i || (st_q.cmp_flag && !clr_cmp_i);
        st_d.ovf_flag = wrap_i  || (st_q.ovf_flag && !clr_ovf_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o      = st_q.lvl;
    assign pwm_o      = st_q.lvl ^ pol_i;
    assign cmp_flag_o = st_q.cmp_flag;
    assign ovf_flag_o = st_q.ovf_flag;
    assign irq_o      = (st_q.cmp_flag && cie_i) || (st_q.ovf_flag && oie_i);

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             pwm_o,
    output logic             cmp_flag_o,
    output logic             ovf_flag_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] limit_w;
    logic [CNT_W-1:0] cmp_w;
    logic             pol_w;
    logic             cie_w;
    logic             oie_w;
    logic             clr_cmp_w;
    logic             clr_ovf_w;
    logic             wrap_w;
    logic             match_w;
    logic             lvl_w;

    pwm_tmr_regs #(.CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .limit_o   (limit_w),
        .cmp_o     (cmp_w),
        .pol_o     (pol_w),
        .cie_o     (cie_w),
        .oie_o     (oie_w),
        .clr_cmp_o (clr_cmp_w),
        .clr_ovf_o (clr_ovf_w)
    );

    pwm_tmr_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .limit_i (limit_w),
        .cmp_i   (cmp_w),
        .count_o (count_o),
        .wrap_o  (wrap_w),
        .match_o (match_w)
    );

    pwm_tmr_output #(.CNT_W(CNT_W)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap_i     (wrap_w),
        .match_i    (match_w),
        .cmp_i      (cmp_w),
        .pol_i      (pol_w),
        .cie_i      (cie_w),
        .oie_i      (oie_w),
        .clr_cmp_i  (clr_cmp_w),
        .clr_ovf_i  (clr_ovf_w),
        .lvl_o      (lvl_w),
        .pwm_o      (pwm_o),
        .cmp_flag_o (cmp_flag_o),
        .ovf_flag_o (ovf_flag_o),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] limit_w,
    input logic [CNT_W-1:0] cmp_w,
    input logic             cie_w,
    input logic             oie_w,
    input logic             lvl_w,
    input logic             cmp_flag_o,
    input logic             ovf_flag_o,
    input logic             irq_o
);

    logic clr_cmp_req;
    assign clr_cmp_req = wr_en && (wr_addr == ADDR_CLR) && wr_data[CLR_CMP_BIT];

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == limit_w) |=> (count_o == '0));

    a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != limit_w) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

    a_r3_ovf_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == limit_w) |=> ovf_flag_o);

    a_r4_active_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o == limit_w) && (cmp_w != '0)) |=> lvl_w);

    a_r5_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o == limit_w) && (cmp_w == '0)) |=> !lvl_w);

    a_r7_cmp_flag_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o != limit_w) && (CNT_W'(count_o + 1'b1) == cmp_w)) |=> cmp_flag_o);

    a_r10_cmp_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag_o && !clr_cmp_req) |=> cmp_flag_o);

    a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!cie_w && !oie_w) |-> !irq_o);

    a_r11_irq_from_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (oie_w && ovf_flag_o) |-> irq_o);

endmodule

bind pwm_timer_chan pwm_tmr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .count_o    (count_o),
    .limit_w    (limit_w),
    .cmp_w      (cmp_w),
    .cie_w      (cie_w),
    .oie_w      (oie_w),
    .lvl_w      (lvl_w),
    .cmp_flag_o (cmp_flag_o),
    .ovf_flag_o (ovf_flag_o),
    .irq_o      (irq_o)
);

// File: tb/pwm_timer_chan_tb.sv
module pwm_timer_chan_tb_top;

    localparam int CNT_W = 16;
    localparam int WDOG  = 190000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] count_o;
    logic             pwm_o;
    logic             cmp_flag_o;
    logic             ovf_flag_o;
    logic             irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_timer_chan #(.CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .count_o    (count_o),
        .pwm_o      (pwm_o),
        .cmp_flag_o (cmp_flag_o),
        .ovf_flag_o (ovf_flag_o),
        .irq_o      (irq_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<%0d", cyc, WDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0d exp=%0d (count=%0d)", tag, act, exp, count_o);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [1:0] a, input int d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_count(input int v);
        while (int'(count_o) != v) @(negedge clk);
    endtask

    function automatic int act_lvl(input int cnt, input int c, input int lim, input int p);
        int a;
        a = (c >= 1 && c <= lim) ? ((cnt < c) ? 1 : 0) : ((c == 0) ? 0 : 1);
        return a ^ p;
    endfunction

    initial begin
        @(negedge clk);
        chk(int'(count_o), 0, "R1 count in reset");
        chk(int'(pwm_o), 0, "R1 pwm in reset");
        chk(int'(cmp_flag_o) + int'(ovf_flag_o) + int'(irq_o), 0, "R1 flags/irq in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(count_o), 1, "R1 first count after reset");
        chk(int'(pwm_o), 0, "R1 pwm after reset");
        chk(int'(ovf_flag_o), 0, "R1 ovf flag after reset");

        // R2: default limit is all ones
        wait_count(16'hFFFF);
        chk(int'(ovf_flag_o), 0, "R2 no wrap before 65535");
        @(negedge clk);
        chk(int'(count_o), 0, "R2 wrap after 65535");
        chk(int'(ovf_flag_o), 1, "R2 ovf flag on default wrap");

        // R3..R7 sweep over small limits, all compare values, both polarities
        for (int lim = 3; lim <= 7; lim++) begin
            for (int c = 0; c <= lim + 2; c++) begin
                for (int p = 0; p <= 1; p++) begin
                    wait_count(0);
                    wr(2'd0, lim);
                    wr(2'd1, c);
                    wr(2'd2, p);
                    wait_count(0);
                    chk(int'(pwm_o), act_lvl(0, c, lim, p), "R4 R6 level at count 0");
                    wr(2'd3, 3);
                    for (int k = 1; k <= lim; k++) begin
                        chk(int'(count_o), k, "R3 count step");
                        chk(int'(pwm_o), act_lvl(k, c, lim, p), "R4 R5 R6 pwm level");
                        @(negedge clk);
                    end
                    chk(int'(count_o), 0, "R3 wrap after limit");
                    chk(int'(ovf_flag_o), 1, "R3 ovf flag on wrap");
                    chk(int'(cmp_flag_o), (c >= 1 && c <= lim) ? 1 : 0, "R7 compare flag");
                end
            end
        end

        // R8: raise compare mid-pulse, effect in same period
        wait_count(0);
        wr(2'd0, 9);
        wr(2'd1, 3);
        wr(2'd2, 0);
        wait_count(0);
        wait_count(1);
        wr(2'd1, 6);
        for (int k = 2; k <= 9; k++) begin
            chk(int'(pwm_o), (k < 6) ? 1 : 0, "R8 lengthened pulse");
            @(negedge clk);
        end

        // R9: lower compare after passing it, old value not reached yet
        wait_count(1);
        wr(2'd3, 1);
        wait_count(4);
        wr(2'd1, 3);
        for (int k = 5; k <= 9; k++) begin
            chk(int'(pwm_o), 1, "R9 pulse held after skipped match");
            chk(int'(cmp_flag_o), 0, "R9 no compare flag");
            @(negedge clk);
        end
        wait_count(3);
        chk(int'(pwm_o), 0, "R9 next period matches new value");
        chk(int'(cmp_flag_o), 1, "R9 flag in next period");

        // R10, R11: sticky flags, selective clear, interrupt enables
        wait_count(0);
        wr(2'd0, 5);
        wr(2'd1, 2);
        wr(2'd2, 2);
        wait_count(0);
        wr(2'd3, 3);
        chk(int'(irq_o), 0, "R11 irq low, flags clear");
        @(negedge clk);
        chk(int'(cmp_flag_o), 1, "R10 compare flag set");
        chk(int'(irq_o), 1, "R11 irq from compare");
        wr(2'd2, 4);
        chk(int'(irq_o), 0, "R11 compare masked, no ovf yet");
        @(negedge clk);
        chk(int'(cmp_flag_o), 1, "R10 compare flag stays set");
        wr(2'd3, 1);
        chk(int'(cmp_flag_o), 0, "R10 compare flag cleared");
        wait_count(0);
        chk(int'(irq_o), 1, "R11 irq from overflow");
        chk(int'(ovf_flag_o), 1, "R10 ovf flag set");
        wr(2'd3, 1);
        chk(int'(ovf_flag_o), 1, "R10 ovf flag kept by bit 0 clear");
        wr(2'd2, 0);
        chk(int'(irq_o), 0, "R11 all masked");
        wait_count(5);
        wr(2'd3, 2);
        chk(int'(ovf_flag_o), 1, "R10 set wins over clear");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule